// File: doc/BRIEF.md
# Comma-Triggered Latency Meter

This block measures how many clock cycles pass between a comma character at one point of a channel's data path and a comma character at a later point. Four symbol taps come in, each carrying an 8-bit symbol and a control flag. Two of them are candidate start points and two are candidate stop points. One select bit picks the start tap and another picks the stop tap. A comma is one of three control symbols. The first comma at the chosen start tap starts a counter, and the first comma at the chosen stop tap freezes the count into a result register.

The result is wider than one read word, so it is split into a high field and a low field. It stays in the result register until it has been read. Reading the high field and then the low field finishes the read and re-arms the block for the next start comma. If the interval is longer than the counter can express, the result saturates at all ones. The result reads as zero when no start comma has been seen.

The controller has four states. `ST_ARMED` waits for a start comma. `ST_COUNTING` runs the counter. `ST_HOLDING` keeps the result. `ST_HALF_READ` records that the high field has been read. The transitions are:
- *start*: `ST_ARMED` to `ST_COUNTING`.
- *stop*: `ST_COUNTING` to `ST_HOLDING`.
- *read-high*: `ST_HOLDING` to `ST_HALF_READ`.
- *read-low*: `ST_HALF_READ` to `ST_ARMED`.

Every other combination holds the current state.

Top module: `comma_latency_meter`

## Requirements
- R1: A tap carries a comma only when its control flag is 1 and its symbol is 0x3C, 0xBC or 0xFC. Any other symbol, or any of these symbols with the flag at 0, is not a comma.
- R2: `start_sel`=0 selects start tap A and 1 selects start tap B. `stop_sel`=0 selects stop tap A and 1 selects stop tap B. Commas on the unselected taps have no effect.
- R3: When the start comma is sampled at clock edge t0 and the stop comma at edge t1, the stored result is t1−t0. `res_hi` shows result bits [19:16] and `res_lo` shows bits [15:0].
- R4: While counting, further start commas are ignored. Only the first one marks t0.
- R5: A stop comma seen while armed, including one in the same cycle as the start comma, is ignored.
- R6: An interval beyond the counter range stores all ones in every result bit.
- R7: The result reads zero after reset, after re-arming, and throughout counting, until a stop comma is captured.
- R8: While a result is held, commas on any tap neither change it nor start a new measurement.
- R9: Pulsing `rd_hi` while holding, then `rd_lo` on a later cycle, clears the result to zero and re-arms the block. `rd_lo` without a preceding `rd_hi` leaves the result held.
- R10: Asynchronous active-low reset puts the block in the armed state with a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_sel | input | 1 | Start tap select (0 = A, 1 = B) |
| stop_sel | input | 1 | Stop tap select (0 = A, 1 = B) |
| start_a_sym | input | 8 | Start tap A symbol |
| start_a_k | input | 1 | Start tap A control flag |
| start_b_sym | input | 8 | Start tap B symbol |
| start_b_k | input | 1 | Start tap B control flag |
| stop_a_sym | input | 8 | Stop tap A symbol |
| stop_a_k | input | 1 | Stop tap A control flag |
| stop_b_sym | input | 8 | Stop tap B symbol |
| stop_b_k | input | 1 | Stop tap B control flag |
| rd_hi | input | 1 | High-field read strobe |
| rd_lo | input | 1 | Low-field read strobe |
| res_hi | output | HI_W (4) | Result high field |
| res_lo | output | LO_W (16) | Result low field |

## Verification
Taps and strobes are sampled on the same rising edge. The result register therefore changes at the edge that samples the stop comma, and again at the edge that samples `rd_lo` in `ST_HALF_READ`. Nothing else moves it.

The bench drives every input at a falling edge and checks the outputs at the falling edge after the edge in question, so each check sees the result exactly one edge after its stimulus. Each length in the vector table is the number of edges from the start symbol to the stop symbol, which makes the expected result that length.

A second instance with a 6-bit counter shares the same inputs and shows saturation at 63 within the run time.

// File: rtl/lat_meter_pkg.sv
package lat_meter_pkg;

    typedef enum logic [1:0] {
        ST_ARMED     = 2'd0,
        ST_COUNTING  = 2'd1,
        ST_HOLDING   = 2'd2,
        ST_HALF_READ = 2'd3
    } lat_state_e;

    localparam logic [7:0] COMMA_K28_1 = 8'h3C;
    localparam logic [7:0] COMMA_K28_5 = 8'hBC;
    localparam logic [7:0] COMMA_K28_7 = 8'hFC;

    function automatic logic is_comma(input logic [7:0] sym, input logic k);
        return k && ((sym == COMMA_K28_1) || (sym == COMMA_K28_5) ||
                     (sym == COMMA_K28_7));
    endfunction

endpackage

// File: rtl/lat_comma_det.sv
module lat_comma_det
    import lat_meter_pkg::*;
(
    input  logic [7:0] sym,
    input  logic       k,
    output logic       hit
);
    always_comb hit = is_comma(sym, k);
endmodule

// File: rtl/lat_sat_counter.sv
module lat_sat_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_ONE;
        end else if (inc && !(&cnt)) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/lat_ctrl_fsm.sv
module lat_ctrl_fsm
    import lat_meter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_hit,
    input  logic       stop_hit,
    input  logic       rd_hi,
    input  logic       rd_lo,
    output lat_state_e state,
    output logic       cnt_load,
    output logic       cnt_inc,
    output logic       res_capture,
    output logic       res_clear
);
    lat_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt   = state;
        cnt_load    = 1'b0;
        cnt_inc     = 1'b0;
        res_capture = 1'b0;
        res_clear   = 1'b0;
        unique case (state)
            ST_ARMED: begin
                if (start_hit) begin
                    cnt_load  = 1'b1;
                    state_nxt = ST_COUNTING;
                end
            end
            ST_COUNTING: begin
                if (stop_hit) begin
                    res_capture = 1'b1;
                    state_nxt   = ST_HOLDING;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_HOLDING: begin
                if (rd_hi) begin
                    state_nxt = ST_HALF_READ;
                end
            end
            ST_HALF_READ: begin
                if (rd_lo) begin
                    res_clear = 1'b1;
                    state_nxt = ST_ARMED;
                end
            end
            default: state_nxt = ST_ARMED;
        endcase
    end
endmodule

// File: rtl/comma_latency_meter.sv
module comma_latency_meter
    import lat_meter_pkg::*;
#(
    parameter int HI_W = 4,
    parameter int LO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_sel,
    input  logic            stop_sel,
    input  logic [7:0]      start_a_sym,
    input  logic            start_a_k,
    input  logic [7:0]      start_b_sym,
    input  logic            start_b_k,
    input  logic [7:0]      stop_a_sym,
    input  logic            stop_a_k,
    input  logic [7:0]      stop_b_sym,
    input  logic            stop_b_k,
    input  logic            rd_hi,
    input  logic            rd_lo,
    output logic [HI_W-1:0] res_hi,
    output logic [LO_W-1:0] res_lo
);
    localparam int CNT_W    = HI_W + LO_W;
    localparam int NUM_TAPS = 4;

    logic [7:0]          tap_sym [NUM_TAPS];
    logic [NUM_TAPS-1:0] tap_k;
    logic [NUM_TAPS-1:0] tap_hit;
    logic                start_hit;
    logic                stop_hit;
    lat_state_e          state;
    logic                cnt_load;
    logic                cnt_inc;
    logic                res_capture;
    logic                res_clear;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    res_q;

    // Tap order: 0 start A, 1 start B, 2 stop A, 3 stop B
    always_comb begin
        tap_sym[0] = start_a_sym;
        tap_sym[1] = start_b_sym;
        tap_sym[2] = stop_a_sym;
        tap_sym[3] = stop_b_sym;
        tap_k      = {stop_b_k, stop_a_k, start_b_k, start_a_k};
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        lat_comma_det u_det (
            .sym (tap_sym[g]),
            .k   (tap_k[g]),
            .hit (tap_hit[g])
        );
    end

    always_comb begin
        start_hit = start_sel ? tap_hit[1] : tap_hit[0];
        stop_hit  = stop_sel  ? tap_hit[3] : tap_hit[2];
    end

    lat_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_hit   (start_hit),
        .stop_hit    (stop_hit),
        .rd_hi       (rd_hi),
        .rd_lo       (rd_lo),
        .state       (state),
        .cnt_load    (cnt_load),
        .cnt_inc     (cnt_inc),
        .res_capture (res_capture),
        .res_clear   (res_clear)
    );

    lat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .inc   (cnt_inc),
        .cnt   (cnt_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (res_clear) begin
            res_q <= '0;
        end else if (res_capture) begin
            res_q <= cnt_q;
        end
    end

    always_comb begin
        res_hi = res_q[CNT_W-1:LO_W];
        res_lo = res_q[LO_W-1:0];
    end
endmodule

// File: rtl/lat_meter_chk.sv
module lat_meter_chk
    import lat_meter_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input lat_state_e       state,
    input logic             start_hit,
    input logic             stop_hit,
    input logic             rd_hi,
    input logic             rd_lo,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] res
);
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNTING && stop_hit) |=> (state == ST_HOLDING && res == $past(cnt)));

    assert_ignore_early_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !start_hit) |=> (state == ST_ARMED));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNTING && (&cnt)) |=> (&cnt));

    assert_zero_until_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED || state == ST_COUNTING) |-> (res == '0));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLDING && !rd_hi) |=> (state == ST_HOLDING && $stable(res)));

    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALF_READ && rd_lo) |=> (state == ST_ARMED && res == '0));
endmodule

bind comma_latency_meter lat_meter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .cnt       (cnt_q),
    .res       (res_q)
);

// File: tb/comma_latency_meter_tb_top.sv
`timescale 1ns/1ps
module comma_latency_meter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_sel = 1'b0, stop_sel = 1'b0;
    logic [7:0]  sa_d = '0, sb_d = '0, pa_d = '0, pb_d = '0;
    logic        sa_k = 1'b0, sb_k = 1'b0, pa_k = 1'b0, pb_k = 1'b0;
    logic        rd_hi = 1'b0, rd_lo = 1'b0;
    logic [3:0]  res_hi;
    logic [15:0] res_lo;
    logic [1:0]  sat_hi;
    logic [3:0]  sat_lo;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    comma_latency_meter dut_i (
        .clk(clk), .rst_n(rst_n), .start_sel(start_sel), .stop_sel(stop_sel),
        .start_a_sym(sa_d), .start_a_k(sa_k), .start_b_sym(sb_d), .start_b_k(sb_k),
        .stop_a_sym(pa_d), .stop_a_k(pa_k), .stop_b_sym(pb_d), .stop_b_k(pb_k),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .res_hi(res_hi), .res_lo(res_lo)
    );

    comma_latency_meter #(.HI_W(2), .LO_W(4)) sat_i (
        .clk(clk), .rst_n(rst_n), .start_sel(start_sel), .stop_sel(stop_sel),
        .start_a_sym(sa_d), .start_a_k(sa_k), .start_b_sym(sb_d), .start_b_k(sb_k),
        .stop_a_sym(pa_d), .stop_a_k(pa_k), .stop_b_sym(pb_d), .stop_b_k(pb_k),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .res_hi(sat_hi), .res_lo(sat_lo)
    );

    // Fields: ssel[55] psel[54] scode[53:46] sk[45] pcode[44:37] pk[36] len[35:20] exp[19:0]
    localparam int NVEC = 8;
    localparam logic [55:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 8'h3C, 1'b1, 8'hBC, 1'b1, 16'd5,    20'd5},
        {1'b1, 1'b0, 8'hBC, 1'b1, 8'hFC, 1'b1, 16'd1,    20'd1},
        {1'b0, 1'b1, 8'hFC, 1'b1, 8'h3C, 1'b1, 16'd37,   20'd37},
        {1'b1, 1'b1, 8'hBC, 1'b1, 8'hBC, 1'b1, 16'd300,  20'd300},
        {1'b0, 1'b0, 8'hBC, 1'b0, 8'hBC, 1'b1, 16'd4,    20'd0},
        {1'b1, 1'b0, 8'h7C, 1'b1, 8'h3C, 1'b1, 16'd4,    20'd0},
        {1'b0, 1'b1, 8'h3D, 1'b1, 8'hFC, 1'b1, 16'd3,    20'd0},
        {1'b1, 1'b1, 8'h3C, 1'b1, 8'hFC, 1'b1, 16'd1000, 20'd1000}
    };

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] main_res();
        return {res_hi, res_lo};
    endfunction

    function automatic logic [19:0] sat_res();
        return {14'd0, sat_hi, sat_lo};
    endfunction

    task automatic idle_taps();
        sa_d = '0; sb_d = '0; pa_d = '0; pb_d = '0;
        sa_k = 1'b0; sb_k = 1'b0; pa_k = 1'b0; pb_k = 1'b0;
    endtask

    // Start symbol sampled at edge P0, stop symbol at edge P0+len.
    task automatic run_measure(input logic ssel, input logic psel,
                               input logic [7:0] scode, input logic sk,
                               input logic [7:0] pcode, input logic pk,
                               input int len, input bit decoy,
                               input int extra_start, input int extra_stop,
                               input bit junk_stop);
        for (int i = 0; i <= len; i++) begin
            @(negedge clk);
            start_sel = ssel;
            stop_sel  = psel;
            idle_taps();
            if (decoy) begin
                if (ssel) begin sa_d = 8'hBC; sa_k = 1'b1; end
                else      begin sb_d = 8'hBC; sb_k = 1'b1; end
                if (psel) begin pa_d = 8'hBC; pa_k = 1'b1; end
                else      begin pb_d = 8'hBC; pb_k = 1'b1; end
            end
            if (i == 0 || i == extra_start) begin
                if (ssel) begin sb_d = scode; sb_k = sk; end
                else      begin sa_d = scode; sa_k = sk; end
            end
            if (i == len || i == extra_stop) begin
                if (psel) begin pb_d = pcode; pb_k = pk; end
                else      begin pa_d = pcode; pa_k = pk; end
            end else if (junk_stop) begin
                if (psel) begin pb_d = (i % 2) ? 8'hBC : 8'h7C; pb_k = (i % 2) ? 1'b0 : 1'b1; end
                else      begin pa_d = (i % 2) ? 8'hBC : 8'h7C; pa_k = (i % 2) ? 1'b0 : 1'b1; end
            end
        end
        @(negedge clk);
        idle_taps();
    endtask

    task automatic pulse_hi();
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
    endtask

    task automatic pulse_lo();
        rd_lo = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset result", main_res(), 20'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 zero after reset", main_res(), 20'd0);

        // Table walk: R1 R2 R3 with decoy commas on the unselected taps
        for (int v = 0; v < NVEC; v++) begin
            logic [55:0] e;
            logic [19:0] ex;
            e  = VECS[v];
            ex = e[19:0];
            run_measure(e[55], e[54], e[53:46], e[45], e[44:37], e[36],
                        int'(e[35:20]), 1'b1, -1, -1, 1'b0);
            check($sformatf("R1/R2/R3 vector %0d", v), main_res(), ex);
            check($sformatf("R6 narrow vector %0d", v), sat_res(), (ex > 20'd63) ? 20'd63 : ex);
            pulse_hi();
            pulse_lo();
            check($sformatf("R9 rearm after vector %0d", v), main_res(), 20'd0);
        end

        // R3: interval crossing into the high field
        run_measure(1'b0, 1'b0, 8'hBC, 1'b1, 8'hBC, 1'b1, 70000, 1'b0, -1, -1, 1'b0);
        check("R3 high field", {16'd0, res_hi}, 20'd1);
        check("R3 low field", {4'd0, res_lo}, 20'd4464);
        check("R6 saturated all ones", sat_res(), 20'd63);
        pulse_hi(); pulse_lo();

        // R6 boundary: 63 exact, 64 saturates
        run_measure(1'b0, 1'b0, 8'h3C, 1'b1, 8'h3C, 1'b1, 63, 1'b0, -1, -1, 1'b0);
        check("R6 at limit", sat_res(), 20'd63);
        pulse_hi(); pulse_lo();
        run_measure(1'b0, 1'b0, 8'h3C, 1'b1, 8'h3C, 1'b1, 64, 1'b0, -1, -1, 1'b0);
        check("R6 one past limit", sat_res(), 20'd63);
        check("R3 unsaturated 64", main_res(), 20'd64);
        pulse_hi(); pulse_lo();

        // R4: second start comma at cycle 2 ignored
        run_measure(1'b1, 1'b0, 8'hFC, 1'b1, 8'hBC, 1'b1, 6, 1'b0, 2, -1, 1'b0);
        check("R4 later start ignored", main_res(), 20'd6);
        pulse_hi(); pulse_lo();

        // R5: stop commas while armed, and together with the start comma
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            stop_sel = 1'b0; pa_d = 8'hBC; pa_k = 1'b1;
        end
        @(negedge clk);
        idle_taps();
        check("R5 stop while armed", main_res(), 20'd0);
        run_measure(1'b0, 1'b0, 8'hBC, 1'b1, 8'hBC, 1'b1, 3, 1'b0, -1, 0, 1'b0);
        check("R5 stop with start ignored", main_res(), 20'd3);
        pulse_hi(); pulse_lo();

        // R1: non-comma symbols on the stop tap do not stop counting
        run_measure(1'b1, 1'b1, 8'h3C, 1'b1, 8'hFC, 1'b1, 9, 1'b0, -1, -1, 1'b1);
        check("R1 non-comma stop ignored", main_res(), 20'd9);

        // R8: commas during hold are ignored
        run_measure(1'b0, 1'b0, 8'hBC, 1'b1, 8'hBC, 1'b1, 2, 1'b1, -1, -1, 1'b0);
        check("R8 held across commas", main_res(), 20'd9);
        // R9: rd_lo alone does not release
        pulse_lo();
        check("R9 low read alone keeps result", main_res(), 20'd9);
        pulse_hi();
        check("R9 result held after high read", main_res(), 20'd9);
        pulse_lo();
        check("R9 cleared after low read", main_res(), 20'd0);

        // R7: zero while counting
        @(negedge clk);
        start_sel = 1'b0; stop_sel = 1'b1; sa_d = 8'hFC; sa_k = 1'b1;
        @(negedge clk);
        idle_taps();
        repeat (5) @(negedge clk);
        check("R7 zero during count", main_res(), 20'd0);
        pb_d = 8'h3C; pb_k = 1'b1;
        @(negedge clk);
        idle_taps();
        check("R3 measured after rearm", main_res(), 20'd6);

        // R10: reset mid-hold clears result
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears held result", main_res(), 20'd0);
        rst_n = 1'b1;
        run_measure(1'b0, 1'b0, 8'hBC, 1'b1, 8'hBC, 1'b1, 2, 1'b0, -1, -1, 1'b0);
        check("R10 armed after reset", main_res(), 20'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule